// File: doc/BRIEF.md
# Mark-Space Modulation Timer

This block produces the gate signal that switches an infrared-style transmitter between bursts and silence. One period has a mark interval, where the gate is open, and then a space interval, where the gate is closed. Each length is a 12-bit value. Software writes the lengths through a small byte-wide register port into holding buffers. The timer copies the buffers into its working state only when a period begins. A one-cycle end-of-period strobe tells the host when to write the values for the following period.

One down counter times both intervals. It counts the mark down to zero. After the underflow it keeps decrementing, and a comparator checks the bitwise complement of the counter against the active space value. When they are equal the space ends. A space value of zero therefore gives marks back to back, which is what frequency-shift bursts need.

There are two counting modes. In time mode the counter advances on a prescaler tick input. In frequency-shift mode it advances on a carrier-period strobe, and a carrier-select output toggles at the end of every period so that an external carrier generator alternates between two frequencies.

Top module: `mst_timer`

## Requirements
- R1: While reset is high and on the first cycle after it, `gate_o`, `cycle_end_o` and `carrier_sel_o` are all 0.
- R2: A register write is taken on a clock edge where `wr_en` is 1. Address 0 loads mark bits 11:8 from data bits 7:4 and space bits 11:8 from data bits 3:0. Address 1 loads mark bits 7:0. Address 2 loads space bits 7:0. A write to address 3 has no effect on the outputs.
- R3: With `enable` at 1, the first selected tick loads the mark buffer into the counter and the space buffer into the active space register, and opens the gate on that same edge. Ticks that arrive before this one have no effect.
- R4: The gate stays open for M+1 selected ticks, where M is the mark value. It closes on the tick where the counter underflows.
- R5: After a mark, the gate stays closed for S selected ticks, where S is the active space value. The space ends on the tick where the complement of the decremented counter equals S, and the gate reopens on that edge.
- R6: When S is 0, the gate never closes. Each period is then M+1 ticks long.
- R7: `cycle_end_o` goes high for exactly one clock cycle after each edge that ends a period. That edge is also the one on which the gate reopens. The strobe does not fire when the timer first starts.
- R8: The buffers are copied into the working state only at the start of a period. A write made during a period changes neither the current mark nor the current space. The new values apply from the next period onward.
- R9: When `fsk_mode` is 0 the tick is `presc_tick`. When `fsk_mode` is 1 the tick is `carrier_tick`. The tick input that is not selected is ignored. On cycles with no selected tick, `gate_o` holds its value and `cycle_end_o` stays 0.
- R10: When `fsk_mode` is 1, `carrier_sel_o` inverts on every edge that ends a period. When `fsk_mode` is 0 it never changes.
- R11: Clearing `enable` closes the gate on the next edge and freezes `carrier_sel_o`. Setting `enable` again restarts the timer with a full mark, as described in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register byte address |
| wr_data | input | 8 | Register write data |
| enable | input | 1 | Timer run enable |
| fsk_mode | input | 1 | 0 = count prescaler ticks, 1 = count carrier periods |
| presc_tick | input | 1 | Time-mode clock enable |
| carrier_tick | input | 1 | Carrier-period strobe used in frequency-shift mode |
| gate_o | output | 1 | Modulator gate, 1 = open (mark) |
| cycle_end_o | output | 1 | One-cycle strobe at the end of each period |
| carrier_sel_o | output | 1 | Carrier frequency select, toggled per period in frequency-shift mode |

## Verification
The assertions check these properties on every cycle:
- the gate closes after `enable` drops;
- gate and strobe hold still on cycles with no tick;
- a started mark never closes before the underflow tick;
- the strobe only appears while the gate is open;
- the carrier select changes only together with the strobe;
- the buffers change only on a write.

The exact mark length and space length are checked only by the bench's scenarios, which compare every output cycle against a model built from R4 and R5. The same scenarios are the only check on these cases:
- the complement comparison when the space is zero or the values are large;
- the handover to buffer values written in the middle of a period;
- the slower tick rates.

// File: rtl/mst_pkg.sv
package mst_pkg;
  typedef enum logic {PH_MARK = 1'b0, PH_SPACE = 1'b1} phase_t;

  localparam logic [1:0] ADDR_HI    = 2'd0;
  localparam logic [1:0] ADDR_MARK  = 2'd1;
  localparam logic [1:0] ADDR_SPACE = 2'd2;
endpackage

// File: rtl/mst_regs.sv
module mst_regs #(
  parameter int PW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [PW-1:0] mark_buf,
  output logic [PW-1:0] space_buf
);
  import mst_pkg::*;
  localparam int HI = PW - DW;

  always_ff @(posedge clk) begin
    if (rst) begin
      mark_buf  <= '0;
      space_buf <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_HI: begin
          mark_buf[PW-1:DW]  <= wr_data[DW-1 -: HI];
          space_buf[PW-1:DW] <= wr_data[HI-1:0];
        end
        ADDR_MARK:  mark_buf[DW-1:0]  <= wr_data;
        ADDR_SPACE: space_buf[DW-1:0] <= wr_data;
        default: ;
      endcase
    end
  end

  a_r8_buffers_only_on_write: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(mark_buf) && $stable(space_buf)));
endmodule

// File: rtl/mst_tick_sel.sv
module mst_tick_sel (
  input  logic fsk_mode,
  input  logic presc_tick,
  input  logic carrier_tick,
  output logic tick
);
  always_comb tick = fsk_mode ? carrier_tick : presc_tick;
endmodule

// File: rtl/mst_cmp.sv
module mst_cmp #(
  parameter int PW = 12
) (
  input  logic [PW-1:0] cnt,
  input  logic [PW-1:0] cnt_dec,
  input  logic [PW-1:0] space_val,
  input  logic          in_space,
  output logic          match
);
  logic cmp_en;
  always_comb begin
    cmp_en = in_space || (cnt == '0);
    match  = cmp_en && ((~cnt_dec) == space_val);
  end
endmodule

// File: rtl/mst_core.sv
module mst_core #(
  parameter int PW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic          fsk_mode,
  input  logic          tick,
  input  logic [PW-1:0] mark_buf,
  input  logic [PW-1:0] space_buf,
  output logic          gate_q,
  output logic          cend_q,
  output logic          csel_q
);
  import mst_pkg::*;

  logic          run_q;
  phase_t        phase_q;
  logic [PW-1:0] cnt_q, spc_q, cnt_dec;
  logic          match;

  always_comb cnt_dec = cnt_q - 1'b1;

  mst_cmp #(.PW(PW)) u_cmp (
    .cnt       (cnt_q),
    .cnt_dec   (cnt_dec),
    .space_val (spc_q),
    .in_space  (phase_q == PH_SPACE),
    .match     (match)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      phase_q <= PH_MARK;
      cnt_q   <= '0;
      spc_q   <= '0;
      gate_q  <= 1'b0;
      cend_q  <= 1'b0;
      csel_q  <= 1'b0;
    end else begin
      cend_q <= 1'b0;
      if (!enable) begin
        run_q  <= 1'b0;
        gate_q <= 1'b0;
      end else if (tick) begin
        if (!run_q) begin
          run_q   <= 1'b1;
          cnt_q   <= mark_buf;
          spc_q   <= space_buf;
          phase_q <= PH_MARK;
          gate_q  <= 1'b1;
        end else if (match) begin
          cnt_q   <= mark_buf;
          spc_q   <= space_buf;
          phase_q <= PH_MARK;
          gate_q  <= 1'b1;
          cend_q  <= 1'b1;
          if (fsk_mode) csel_q <= ~csel_q;
        end else begin
          cnt_q <= cnt_dec;
          if (phase_q == PH_MARK && cnt_q == '0) begin
            phase_q <= PH_SPACE;
            gate_q  <= 1'b0;
          end
        end
      end
    end
  end

  a_r11_closed_when_off: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !gate_q);
  a_r7_strobe_with_open_gate: assert property (@(posedge clk) disable iff (rst)
    cend_q |-> gate_q);
  a_r10_select_moves_with_strobe: assert property (@(posedge clk) disable iff (rst)
    (csel_q != $past(csel_q)) |-> cend_q);
  a_r9_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
    (enable && !tick) |=> ($stable(gate_q) && !cend_q));
  a_r4_mark_stays_open: assert property (@(posedge clk) disable iff (rst)
    (enable && tick && run_q && phase_q == PH_MARK && cnt_q != '0) |=> gate_q);
endmodule

// File: rtl/mst_timer.sv
module mst_timer #(
  parameter int PW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          enable,
  input  logic          fsk_mode,
  input  logic          presc_tick,
  input  logic          carrier_tick,
  output logic          gate_o,
  output logic          cycle_end_o,
  output logic          carrier_sel_o
);
  logic [PW-1:0] mark_buf, space_buf;
  logic          tick;

  mst_regs #(.PW(PW), .DW(DW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .mark_buf  (mark_buf),
    .space_buf (space_buf)
  );

  mst_tick_sel u_tick (
    .fsk_mode     (fsk_mode),
    .presc_tick   (presc_tick),
    .carrier_tick (carrier_tick),
    .tick         (tick)
  );

  mst_core #(.PW(PW)) u_core (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .fsk_mode  (fsk_mode),
    .tick      (tick),
    .mark_buf  (mark_buf),
    .space_buf (space_buf),
    .gate_q    (gate_o),
    .cend_q    (cycle_end_o),
    .csel_q    (carrier_sel_o)
  );
endmodule

// File: tb/mst_timer_tb.sv
`timescale 1ns/1ps
module mst_timer_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       enable = 1'b0;
  logic       fsk_mode = 1'b0;
  logic       presc_tick = 1'b0;
  logic       carrier_tick = 1'b0;
  logic       gate_o, cycle_end_o, carrier_sel_o;

  int checks = 0;
  int errors = 0;
  string cur_tag = "";
  logic csel_exp = 1'b0;

  typedef struct { logic g; logic ce; logic cs; } exp_t;
  exp_t sb_q[$];

  always #4 clk = ~clk;

  mst_timer u_dut (
    .clk (clk), .rst (rst), .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
    .enable (enable), .fsk_mode (fsk_mode), .presc_tick (presc_tick),
    .carrier_tick (carrier_tick), .gate_o (gate_o), .cycle_end_o (cycle_end_o),
    .carrier_sel_o (carrier_sel_o)
  );

  // Monitor: compares each produced cycle against the scoreboard.
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (gate_o !== e.g || cycle_end_o !== e.ce || carrier_sel_o !== e.cs) begin
        errors++;
        $display("FAIL %s gate/end/sel actual %b%b%b expected %b%b%b", cur_tag,
                 gate_o, cycle_end_o, carrier_sel_o, e.g, e.ce, e.cs);
      end
    end
  end

  task automatic check1(input string tag, input logic act, input logic expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual %b expected %b", tag, act, expv);
    end
  endtask

  task automatic write_byte(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_ticks(input bit fsk, input logic t);
    if (fsk) begin carrier_tick = t; presc_tick = 1'b1; end
    else     begin presc_tick = t; carrier_tick = 1'b1; end
  endtask

  // Driver: programs buffers, predicts every cycle, then drives ticks.
  task automatic run(input int m, input int s, input int m2, input int s2, input bit fsk,
                     input int div, input int n, input bit wr_mid, input string tag);
    logic [11:0] mm = m[11:0];
    logic [11:0] ss = s[11:0];
    logic [11:0] mm2 = m2[11:0];
    logic [11:0] ss2 = s2[11:0];
    exp_t plan[$];
    int t = 0, pos = 0, cm = m, cs = s;
    logic g = 1'b0, c = csel_exp;
    write_byte(2'd0, {mm[11:8], ss[11:8]});
    write_byte(2'd1, mm[7:0]);
    write_byte(2'd2, ss[7:0]);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      logic ce = 1'b0;
      if (i % div == 0) begin
        if (t == 0) begin
          pos = 0;
        end else begin
          pos++;
          if (pos == cm + 1 + cs) begin
            pos = 0; cm = m2; cs = s2; ce = 1'b1;
            if (fsk) c = ~c;
          end
        end
        g = (pos <= cm);
        t++;
      end
      e.g = g; e.ce = ce; e.cs = c;
      plan.push_back(e);
    end
    @(negedge clk);
    cur_tag = tag;
    fsk_mode = fsk;
    enable = 1'b1;
    set_ticks(fsk, 1'b1);
    #1;
    foreach (plan[k]) sb_q.push_back(plan[k]);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      set_ticks(fsk, ((i + 1) % div == 0));
      if (wr_mid) begin
        case (i)
          0: begin wr_en = 1'b1; wr_addr = 2'd0; wr_data = {mm2[11:8], ss2[11:8]}; end
          1: begin wr_addr = 2'd1; wr_data = mm2[7:0]; end
          2: begin wr_addr = 2'd2; wr_data = ss2[7:0]; end
          3: wr_en = 1'b0;
          default: ;
        endcase
      end
    end
    csel_exp = c;
    enable = 1'b0;
    @(negedge clk);
    check1("R11 gate closed after disable", gate_o, 1'b0);
    check1("R11 no strobe after disable", cycle_end_o, 1'b0);
    check1("R11 carrier select frozen", carrier_sel_o, csel_exp);
    checks++;
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL %s scoreboard left actual %0d expected 0", tag, sb_q.size());
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check1("R1 gate in reset", gate_o, 1'b0);
    check1("R1 select in reset", carrier_sel_o, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check1("R1 gate after reset", gate_o, 1'b0);
    check1("R1 strobe after reset", cycle_end_o, 1'b0);
    check1("R1 select after reset", carrier_sel_o, 1'b0);

    run(3, 2, 3, 2, 1'b0, 1, 30, 1'b0, "R3 R4 R5 R7 time basic");
    run(2, 4, 2, 4, 1'b0, 3, 60, 1'b0, "R9 time slow tick");
    run(4, 0, 4, 0, 1'b0, 1, 20, 1'b0, "R6 zero space");
    run(1, 2, 1, 2, 1'b1, 2, 40, 1'b0, "R10 fsk with space");
    run(2, 0, 2, 0, 1'b1, 1, 20, 1'b0, "R10 R6 fsk back to back");
    run(0, 0, 0, 0, 1'b0, 1, 8, 1'b0, "R6 R7 minimal period");
    run(3, 3, 1, 5, 1'b0, 1, 40, 1'b1, "R8 mid period write");
    write_byte(2'd3, 8'hFF);
    run(12'h10A, 12'h0F3, 12'h10A, 12'h0F3, 1'b0, 1, 600, 1'b0, "R2 wide values");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule